// File: doc/BRIEF.md
# Partial-Tag Snoop Filter

This block sits beside the snoop controller of a small bus-based multiprocessor. For every line held in each core's private four-way data cache it keeps a shadow entry with only the eight lowest tag bits, a valid bit and a dirty bit. When a core issues a coherence request, the block compares the request's partial tag against the shadow entries of every other core in the addressed set. It returns the set of remote cores that might hold the line, so the full snoop goes to those cores only. When no remote core matches, it raises a bypass flag, and the request goes straight to the next cache level without any snoop.

Each accepted request also takes a slot in a small pending-request table. The slot records the line address, the requesting core, the victim way and whether the incoming line will be dirty. When the fill completes, the slot id comes back and the block writes the new partial tag into the recorded core, set and way. Eviction notices clear an entry's valid bit. Writeback notices clear its dirty bit.

Top module: `ptag_snoop_filter`

## Requirements
- R1: After reset no entry is valid, `req_ready` is 1 and `lk_valid` is 0, so the first lookup reports `lk_bypass`=1 and `lk_snoop`=0.
- R2: The lookup result (`lk_valid`, `lk_snoop`, `lk_owner`, `lk_bypass`, `lk_id`) appears exactly one cycle after a request is accepted (`req_valid` and `req_ready` both 1). `lk_valid` is 0 in cycles that follow no acceptance.
- R3: Address bits [5:0] are the line offset, [9:6] the set and [17:10] the partial tag. Bit c of `lk_snoop` is 1 when core c has a valid entry in that set, in any way, whose partial tag equals the request's.
- R4: When no remote core matches, `lk_bypass` is 1 and `lk_snoop` is 0. Otherwise `lk_bypass` is 0.
- R5: The requesting core's own entries never set its own `lk_snoop` bit.
- R6: Address bits above bit 17 and the offset bits are ignored, so addresses that differ only there give the same result.
- R7: An accepted request takes the lowest-numbered free table slot, reported on `lk_id`. The slot stores the address, core, `req_way` and `req_dirty`.
- R8: A `fill_valid` pulse for an occupied slot writes the slot's partial tag into its core, set and way, replacing what was there. The entry becomes valid with a dirty bit equal to the stored flag, and the slot is freed.
- R9: An `evict_valid` pulse clears the valid bit of entry (`evict_core`, `evict_set`, `evict_way`).
- R10: A `wb_valid` pulse clears the dirty bit of entry (`wb_core`, `wb_set`, `wb_way`) and leaves it valid.
- R11: Bit c of `lk_owner` is 1 when a remote core c has a matching entry that is both valid and dirty.
- R12: While all 8 slots are taken, `req_ready` is 0 and no request is accepted. A fill frees a slot and raises `req_ready` after that edge.
- R13: A lookup sees the entries as they were before the updates made on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | A free table slot exists |
| req_addr | input | 32 | Request byte address |
| req_core | input | 2 | Requesting core |
| req_way | input | 2 | Victim way in the requester's cache |
| req_dirty | input | 1 | Incoming line will be dirty |
| lk_valid | output | 1 | Lookup result valid |
| lk_snoop | output | 4 | Remote cores whose partial tag matched |
| lk_owner | output | 4 | Matching remote cores whose entry is dirty |
| lk_bypass | output | 1 | No remote match; skip the snoop |
| lk_id | output | 3 | Table slot given to the request |
| fill_valid | input | 1 | Fill completed |
| fill_id | input | 3 | Slot of the completed fill |
| evict_valid | input | 1 | Eviction notice |
| evict_core | input | 2 | Evicting core |
| evict_set | input | 4 | Set of the evicted line |
| evict_way | input | 2 | Way of the evicted line |
| wb_valid | input | 1 | Writeback notice |
| wb_core | input | 2 | Writing-back core |
| wb_set | input | 4 | Set of the written-back line |
| wb_way | input | 2 | Way of the written-back line |

## Verification
The bench aims at partial-tag aliasing, where a design that compared extra upper bits would miss a false hit that must be snooped. It also checks self-exclusion, where a mistake would show the requester's own bit in `lk_snoop`, and a fill that lands on an occupied way, where a design that did not overwrite would keep snooping the old line. It tests a writeback that must keep the entry valid, an eviction on the same edge as a lookup that must not yet affect the result, and a full table, where a leaking design would accept a ninth request or hand out a slot that is not the lowest free one.

// File: rtl/ptag_snoop_filter.sv
`timescale 1ns/1ps
module ptag_snoop_filter #(
  parameter int NCORES     = 4,
  parameter int NWAYS      = 4,
  parameter int NSETS      = 16,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int PTAG_W     = 8,
  parameter int PRT_DEPTH  = 8,
  localparam int CORE_W  = $clog2(NCORES),
  localparam int WAY_W   = $clog2(NWAYS),
  localparam int IDX_W   = $clog2(NSETS),
  localparam int OFFS_W  = $clog2(LINE_BYTES),
  localparam int TAG_LSB = OFFS_W + IDX_W,
  localparam int PRT_W   = $clog2(PRT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CORE_W-1:0] req_core,
  input  logic [WAY_W-1:0]  req_way,
  input  logic              req_dirty,
  output logic              lk_valid,
  output logic [NCORES-1:0] lk_snoop,
  output logic [NCORES-1:0] lk_owner,
  output logic              lk_bypass,
  output logic [PRT_W-1:0]  lk_id,
  input  logic              fill_valid,
  input  logic [PRT_W-1:0]  fill_id,
  input  logic              evict_valid,
  input  logic [CORE_W-1:0] evict_core,
  input  logic [IDX_W-1:0]  evict_set,
  input  logic [WAY_W-1:0]  evict_way,
  input  logic              wb_valid,
  input  logic [CORE_W-1:0] wb_core,
  input  logic [IDX_W-1:0]  wb_set,
  input  logic [WAY_W-1:0]  wb_way
);

  logic [PTAG_W-1:0] tag_q [NCORES][NSETS][NWAYS];
  logic              vld_q [NCORES][NSETS][NWAYS];
  logic              drt_q [NCORES][NSETS][NWAYS];

  logic [PRT_DEPTH-1:0] pv_q;
  logic [ADDR_W-1:0]    pa_q [PRT_DEPTH];
  logic [CORE_W-1:0]    pc_q [PRT_DEPTH];
  logic [WAY_W-1:0]     pw_q [PRT_DEPTH];
  logic                 pd_q [PRT_DEPTH];

  wire [IDX_W-1:0]  r_set = req_addr[OFFS_W +: IDX_W];
  wire [PTAG_W-1:0] r_tag = req_addr[TAG_LSB +: PTAG_W];
  wire              accept = req_valid && req_ready;
  wire              fill_ok = fill_valid && pv_q[fill_id];
  wire [ADDR_W-1:0] f_addr = pa_q[fill_id];
  wire [IDX_W-1:0]  f_set = f_addr[OFFS_W +: IDX_W];

  assign req_ready = ~&pv_q;

  logic [NCORES-1:0] match, dmatch;
  always_comb begin
    match  = '0;
    dmatch = '0;
    for (int c = 0; c < NCORES; c++)
      for (int w = 0; w < NWAYS; w++)
        if (CORE_W'(c) != req_core && vld_q[c][r_set][w] && tag_q[c][r_set][w] == r_tag) begin
          match[c] = 1'b1;
          if (drt_q[c][r_set][w]) dmatch[c] = 1'b1;
        end
  end

  logic [PRT_W-1:0] free_id;
  always_comb begin
    free_id = '0;
    for (int i = PRT_DEPTH-1; i >= 0; i--)
      if (!pv_q[i]) free_id = PRT_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q      <= '0;
      lk_valid  <= 1'b0;
      lk_snoop  <= '0;
      lk_owner  <= '0;
      lk_bypass <= 1'b0;
      lk_id     <= '0;
      for (int c = 0; c < NCORES; c++)
        for (int s = 0; s < NSETS; s++)
          for (int w = 0; w < NWAYS; w++) begin
            vld_q[c][s][w] <= 1'b0;
            drt_q[c][s][w] <= 1'b0;
          end
    end else begin
      lk_valid <= accept;
      if (accept) begin
        lk_snoop       <= match;
        lk_owner       <= dmatch;
        lk_bypass      <= ~|match;
        lk_id          <= free_id;
        pv_q[free_id]  <= 1'b1;
        pa_q[free_id]  <= req_addr;
        pc_q[free_id]  <= req_core;
        pw_q[free_id]  <= req_way;
        pd_q[free_id]  <= req_dirty;
      end
      if (wb_valid)
        drt_q[wb_core][wb_set][wb_way] <= 1'b0;
      if (evict_valid)
        vld_q[evict_core][evict_set][evict_way] <= 1'b0;
      if (fill_ok) begin
        pv_q[fill_id] <= 1'b0;
        tag_q[pc_q[fill_id]][f_set][pw_q[fill_id]] <= f_addr[TAG_LSB +: PTAG_W];
        vld_q[pc_q[fill_id]][f_set][pw_q[fill_id]] <= 1'b1;
        drt_q[pc_q[fill_id]][f_set][pw_q[fill_id]] <= pd_q[fill_id];
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> lk_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !lk_valid); // R2
  AST_SELF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !lk_snoop[$past(req_core)]); // R5
  AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_bypass == (lk_snoop == '0))); // R4
  AST_OWNER_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ((lk_owner & ~lk_snoop) == '0)); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !fill_valid) |=> !req_ready); // R12

endmodule

// File: tb/ptag_snoop_filter_bench.sv
`timescale 1ns/1ps
module ptag_snoop_filter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_dirty = 0;
  logic        req_ready;
  logic [31:0] req_addr = 0;
  logic [1:0]  req_core = 0, req_way = 0;
  logic        lk_valid, lk_bypass;
  logic [3:0]  lk_snoop, lk_owner;
  logic [2:0]  lk_id;
  logic        fill_valid = 0;
  logic [2:0]  fill_id = 0;
  logic        evict_valid = 0, wb_valid = 0;
  logic [1:0]  evict_core = 0, evict_way = 0, wb_core = 0, wb_way = 0;
  logic [3:0]  evict_set = 0, wb_set = 0;

  ptag_snoop_filter u_ptag_snoop_filter (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] a, input logic [1:0] c, input logic [1:0] w, input logic d);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_core = c; req_way = w; req_dirty = d;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic do_fill(input logic [2:0] id);
    @(negedge clk);
    fill_valid = 1; fill_id = id;
    @(posedge clk); #1;
    fill_valid = 0;
  endtask

  // {addr, exp snoop, exp owner, exp bypass}; requester core 3
  localparam logic [40:0] TBL [6] = '{
    {32'h0000_4840, 4'b0101, 4'b0001, 1'b0},
    {32'h0000_D040, 4'b0010, 4'b0000, 1'b0},
    {32'h0000_4880, 4'b0000, 4'b0000, 1'b1},
    {32'h0000_D0C0, 4'b0000, 4'b0000, 1'b1},
    {32'h0010_4840, 4'b0101, 4'b0001, 1'b0},
    {32'h0000_487F, 4'b0101, 4'b0001, 1'b0}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no result in reset", lk_valid, 0);
    @(negedge clk); rst_n = 1;

    do_req(32'h0000_4840, 0, 2, 1);
    chk("R1 first lookup bypass", lk_bypass, 1);
    chk("R1 first lookup snoop", lk_snoop, 0);
    chk("R2 result valid", lk_valid, 1);
    chk("R7 first slot", lk_id, 0);
    do_fill(0);
    chk("R2 no result without request", lk_valid, 0);
    do_req(32'h0000_D040, 1, 0, 0);
    chk("R7 reused slot", lk_id, 0);
    do_fill(0);
    do_req(32'h0010_4840, 2, 3, 0);
    chk("R6 alias seen by core0", lk_snoop, 4'b0001);
    do_fill(0);

    for (int i = 0; i < 6; i++) begin
      do_req(TBL[i][40:9], 3, 0, 0);
      chk($sformatf("R3 row %0d snoop", i), lk_snoop, TBL[i][8:5]);
      chk($sformatf("R11 row %0d owner", i), lk_owner, TBL[i][4:1]);
      chk($sformatf("R4 row %0d bypass", i), lk_bypass, TBL[i][0]);
      chk($sformatf("R7 row %0d slot", i), lk_id, 0);
      do_fill(0);
    end

    do_req(32'h0000_4840, 0, 1, 0);
    chk("R5 own core excluded", lk_snoop, 4'b1100);
    chk("R7 slot 0", lk_id, 0);
    @(posedge clk); #1;
    chk("R2 valid drops", lk_valid, 0);

    do_req(32'h0000_4840, 1, 0, 0);
    chk("R11 dirty owner", lk_owner, 4'b0001);
    chk("R3 three matches", lk_snoop, 4'b1101);
    chk("R7 slot 1", lk_id, 1);

    @(negedge clk); wb_valid = 1; wb_core = 0; wb_set = 1; wb_way = 2;
    @(posedge clk); #1; wb_valid = 0;
    do_req(32'h0000_4840, 1, 0, 0);
    chk("R10 dirty cleared", lk_owner, 4'b0000);
    chk("R10 still valid", lk_snoop, 4'b1101);

    @(negedge clk); evict_valid = 1; evict_core = 2; evict_set = 1; evict_way = 3;
    @(posedge clk); #1; evict_valid = 0;
    do_req(32'h0000_4840, 1, 0, 0);
    chk("R9 evicted entry gone", lk_snoop, 4'b1001);

    @(negedge clk);
    evict_valid = 1; evict_core = 3; evict_set = 1; evict_way = 0;
    req_valid = 1; req_addr = 32'h0000_4840; req_core = 1; req_way = 0; req_dirty = 0;
    @(posedge clk); #1; evict_valid = 0; req_valid = 0;
    chk("R13 lookup sees old state", lk_snoop, 4'b1001);
    chk("R7 slot 4", lk_id, 4);
    do_req(32'h0000_4840, 1, 0, 0);
    chk("R9 same-edge evict applied", lk_snoop, 4'b0001);

    do_req(32'h0000_4880, 2, 0, 0);
    chk("R3 set 2 match", lk_snoop, 4'b1000);
    do_req(32'h0000_0100, 2, 0, 0);
    chk("R7 slot 7", lk_id, 7);
    chk("R4 bypass set 4", lk_bypass, 1);
    chk("R12 full not ready", req_ready, 0);

    @(negedge clk); req_valid = 1; req_addr = 32'h0000_4840; req_core = 0;
    @(posedge clk); #1; req_valid = 0;
    chk("R12 stalled request not accepted", lk_valid, 0);

    do_fill(3);
    chk("R12 ready after fill", req_ready, 1);
    do_req(32'h0000_D040, 0, 0, 0);
    chk("R7 lowest free slot", lk_id, 3);
    chk("R8 replaced line gone", lk_bypass, 1);

    do_fill(4);
    do_req(32'h0000_D0C0, 1, 2, 1);
    chk("R7 slot 4 again", lk_id, 4);
    chk("R3 set 3 match", lk_snoop, 4'b1000);
    do_fill(4);
    do_req(32'h0000_D0C0, 0, 0, 0);
    chk("R8 fill installs", lk_snoop, 4'b1010);
    chk("R8 fill installs dirty", lk_owner, 4'b0010);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule